// File: doc/BRIEF.md
# Local Scan Port Chain Configurator

This block sits between one upstream IEEE 1149.1 test interface and seven local scan ports. A mode register selects the ports that take part in the scan path. Every selected port is spliced into one serial chain in ascending port order. Every port that is not selected is parked: its TMS is held low, so its TAP stays in the stable state it was parked in. When no port is in the chain, a single bypass flop carries the upstream TDI to the upstream TDO.

There are three modes. Park mode parks every port. Chain mode inserts the ports named by a bit mask. Transparent mode passes the upstream pins to exactly one port, chosen by an index. A port can only leave or join the path at a safe moment. It is parked only while the upstream TAP is in a stable state (Run-Test/Idle, Pause-DR or Pause-IR), and it records which of those states that was. It rejoins only when the upstream TAP is back in that same recorded state. The TAP controller that reports the upstream state, the address decoding and any master/slave port swap are outside this block.

All registers run on the upstream TCK. Each port also has its own TRST output. An output-enable input gates the local port drivers. Ports 0 to 3 each raise a flag while their drivers are off, so an alternate master can take over.

Top module: `lsp_chain_cfg`

## Requirements
- R1: While `rst_n` is low, every `lsp_trst_n` bit is 0. After reset, all ports are parked, and each port's recorded state is Run-Test/Idle (code 1). Every `lsp_tms` bit is 0, and the mode register holds park.
- R2: When `cfg_load` is high at a TCK rising edge, the mode register captures `cfg_op`, `cfg_mask` and `cfg_sel`. The op codes are: 0 park, 1 chain, 2 transparent, 3 park. The ports act on the new value at the following rising edge, not at the load edge.
- R3: Active ports form one chain in ascending index. The lowest active port receives `up_tdi`. Each later active port receives the `lsp_tdo` of the previous active port. `up_tdo` equals the `lsp_tdo` of the highest active port.
- R4: A parked port drives `lsp_tms` = 0. An active port drives `lsp_tms` = `up_tms`.
- R5: A parked port that is wanted becomes active at a rising edge only if `up_stable` equals its recorded state code. Otherwise it stays parked.
- R6: An active port that is not wanted is parked at a rising edge only if `up_stable` is nonzero. The codes are 1 Run-Test/Idle, 2 Pause-DR, 3 Pause-IR and 0 not stable. On parking, the port records that code.
- R7: With no active port, `up_tdo` equals the `up_tdi` sampled at the previous TCK rising edge.
- R8: In transparent mode, `cfg_sel` values 0 to 6 want that single port only. Values of 7 and above want no port, so all ports end up parked.
- R9: For an active port, `lsp_trst_n` follows `up_trst_n`. For a parked port, `lsp_trst_n` is held at 1, outside reset.
- R10: Every `lsp_oe` bit equals `oe`. `lsp_hiz_flag[i]` is the inverse of `oe` for ports 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Upstream test clock; all registers use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Loads the mode register |
| cfg_op | input | 2 | Mode: 0 park, 1 chain, 2 transparent, 3 park |
| cfg_mask | input | 7 | Chain mode: bit i inserts port i |
| cfg_sel | input | 3 | Transparent mode port index |
| up_stable | input | 2 | Upstream TAP stable-state code (0 none, 1 RTI, 2 Pause-DR, 3 Pause-IR) |
| up_tms | input | 1 | Upstream TMS |
| up_tdi | input | 1 | Upstream TDI |
| up_trst_n | input | 1 | Upstream TRST, active low |
| up_tdo | output | 1 | Upstream TDO |
| oe | input | 1 | Local port output enable |
| lsp_tck | output | 7 | Per-port TCK |
| lsp_tms | output | 7 | Per-port TMS |
| lsp_tdi | output | 7 | Per-port TDI |
| lsp_tdo | input | 7 | Per-port TDO |
| lsp_trst_n | output | 7 | Per-port TRST, active low |
| lsp_oe | output | 7 | Per-port driver enable |
| lsp_hiz_flag | output | 4 | High while ports 0 to 3 are not driven |

## Verification
The bench parks a port in Pause-DR and then asks for it back while the upstream TAP sits in Run-Test/Idle. A design that ignores the recorded state would let TMS through and walk that TAP out of Pause-DR. It also tries to park a port while the upstream state is not stable. A design that parks it anyway would strand that TAP mid-scan. The chain is checked with a sparse mask, so that a design that chains by neighbour instead of by the next active port would route the wrong TDO. Transparent index 7 is checked to confirm it selects nothing rather than wrapping round, and the bypass case is checked for its one-cycle delay.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  typedef enum logic [1:0] {
    OP_PARK  = 2'd0,
    OP_CHAIN = 2'd1,
    OP_XPAR  = 2'd2,
    OP_RSV   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_RTI  = 2'd1,
    ST_PDR  = 2'd2,
    ST_PIR  = 2'd3
  } stable_e;
endpackage

// File: rtl/lsp_mode_dec.sv
module lsp_mode_dec
  import lsp_pkg::*;
#(
  parameter int NPORT = 7,
  parameter int SELW  = 3
) (
  input  op_e              op,
  input  logic [NPORT-1:0] mask,
  input  logic [SELW-1:0]  sel,
  output logic [NPORT-1:0] want
);
  always_comb begin
    want = '0;
    unique case (op)
      OP_CHAIN: want = mask;
      OP_XPAR: begin
        for (int i = 0; i < NPORT; i++)
          want[i] = (int'(sel) == i);
      end
      default: want = '0;
    endcase
  end
endmodule

// File: rtl/lsp_port_ctl.sv
module lsp_port_ctl
  import lsp_pkg::*;
(
  input  logic    tck,
  input  logic    rst_n,
  input  logic    want,
  input  stable_e up_stable,
  input  logic    up_tms,
  input  logic    up_trst_n,
  output logic    act,
  output logic    tms_o,
  output logic    trst_n_o
);
  stable_e pst_q;
  logic    act_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pst_q <= ST_RTI;
    end else if (act_q) begin
      if (!want && up_stable != ST_NONE) begin
        act_q <= 1'b0;
        pst_q <= up_stable;
      end
    end else if (want && up_stable == pst_q) begin
      act_q <= 1'b1;
    end
  end

  assign act      = act_q;
  assign tms_o    = act_q & up_tms;
  assign trst_n_o = rst_n & (~act_q | up_trst_n);

  // R5: rejoining happens only in the state the port was parked in
  a_r5_unpark_match: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(act_q) |-> ($past(up_stable) == $past(pst_q)));

  // R6: leaving the chain only from a stable upstream state
  a_r6_park_stable: assert property (@(posedge tck) disable iff (!rst_n)
    $fell(act_q) |-> ($past(up_stable) != ST_NONE));

  // R6: the recorded code changes only at a park event
  a_r6_pst_hold: assert property (@(posedge tck) disable iff (!rst_n)
    !$fell(act_q) |-> $stable(pst_q));
endmodule

// File: rtl/lsp_chain_route.sv
module lsp_chain_route #(
  parameter int NPORT = 7
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic [NPORT-1:0] act,
  input  logic             up_tdi,
  input  logic [NPORT-1:0] lsp_tdo,
  output logic [NPORT-1:0] lsp_tdi,
  output logic             up_tdo
);
  logic byp_q;
  logic tail;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else        byp_q <= up_tdi;
  end

  always_comb begin
    tail = up_tdi;
    for (int i = 0; i < NPORT; i++) begin
      lsp_tdi[i] = tail;
      if (act[i]) tail = lsp_tdo[i];
    end
  end

  assign up_tdo = (|act) ? tail : byp_q;

  // R7: one-cycle bypass when the chain is empty
  a_r7_bypass_delay: assert property (@(posedge tck) disable iff (!rst_n)
    (act == '0 && $past(rst_n)) |-> (up_tdo == $past(up_tdi)));
endmodule

// File: rtl/lsp_chain_cfg.sv
module lsp_chain_cfg
  import lsp_pkg::*;
#(
  parameter int NPORT = 7,
  parameter int SELW  = $clog2(NPORT + 1),
  parameter int NFLAG = 4
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [1:0]       cfg_op,
  input  logic [NPORT-1:0] cfg_mask,
  input  logic [SELW-1:0]  cfg_sel,
  input  logic [1:0]       up_stable,
  input  logic             up_tms,
  input  logic             up_tdi,
  input  logic             up_trst_n,
  output logic             up_tdo,
  input  logic             oe,
  output logic [NPORT-1:0] lsp_tck,
  output logic [NPORT-1:0] lsp_tms,
  output logic [NPORT-1:0] lsp_tdi,
  input  logic [NPORT-1:0] lsp_tdo,
  output logic [NPORT-1:0] lsp_trst_n,
  output logic [NPORT-1:0] lsp_oe,
  output logic [NFLAG-1:0] lsp_hiz_flag
);
  op_e              op_q;
  logic [NPORT-1:0] mask_q;
  logic [SELW-1:0]  sel_q;
  logic [NPORT-1:0] want;
  logic [NPORT-1:0] port_act;
  stable_e          st;

  assign st = stable_e'(up_stable);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PARK;
      mask_q <= '0;
      sel_q  <= '0;
    end else if (cfg_load) begin
      op_q   <= op_e'(cfg_op);
      mask_q <= cfg_mask;
      sel_q  <= cfg_sel;
    end
  end

  lsp_mode_dec #(.NPORT(NPORT), .SELW(SELW)) u_dec (
    .op   (op_q),
    .mask (mask_q),
    .sel  (sel_q),
    .want (want)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    lsp_port_ctl u_port (
      .tck       (tck),
      .rst_n     (rst_n),
      .want      (want[g]),
      .up_stable (st),
      .up_tms    (up_tms),
      .up_trst_n (up_trst_n),
      .act       (port_act[g]),
      .tms_o     (lsp_tms[g]),
      .trst_n_o  (lsp_trst_n[g])
    );
  end

  lsp_chain_route #(.NPORT(NPORT)) u_route (
    .tck     (tck),
    .rst_n   (rst_n),
    .act     (port_act),
    .up_tdi  (up_tdi),
    .lsp_tdo (lsp_tdo),
    .lsp_tdi (lsp_tdi),
    .up_tdo  (up_tdo)
  );

  assign lsp_tck      = {NPORT{tck}};
  assign lsp_oe       = {NPORT{oe}};
  assign lsp_hiz_flag = {NFLAG{~oe}};

  // R2/R6: a park mode seen at a stable edge leaves every port parked
  a_r2_park_all: assert property (@(posedge tck) disable iff (!rst_n)
    $past(op_q == OP_PARK && st != ST_NONE) |-> (port_act == '0));

  // R8: transparent mode never has more than one port in the path once stable
  a_r8_xpar_single: assert property (@(posedge tck) disable iff (!rst_n)
    $past(op_q == OP_XPAR && st != ST_NONE) |-> ($countones(port_act) <= 1));

  // R4: parked ports keep TMS low
  a_r4_parked_tms: assert property (@(posedge tck) disable iff (!rst_n)
    (port_act == '0) |-> (lsp_tms == '0));
endmodule

// File: tb/lsp_chain_cfg_tb.sv
module lsp_chain_cfg_tb;
  localparam int N = 7;

  logic tck = 0;
  logic rst_n = 0;
  logic cfg_load = 0;
  logic [1:0] cfg_op = 0;
  logic [N-1:0] cfg_mask = 0;
  logic [2:0] cfg_sel = 0;
  logic [1:0] up_stable = 1;
  logic up_tms = 0, up_tdi = 0, up_trst_n = 1, oe = 1;
  logic [N-1:0] lsp_tdo = 0;
  logic up_tdo;
  logic [N-1:0] lsp_tck, lsp_tms, lsp_tdi, lsp_trst_n, lsp_oe;
  logic [3:0] lsp_hiz_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 tck = ~tck;

  lsp_chain_cfg u_dut (
    .tck(tck), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_op(cfg_op),
    .cfg_mask(cfg_mask), .cfg_sel(cfg_sel), .up_stable(up_stable),
    .up_tms(up_tms), .up_tdi(up_tdi), .up_trst_n(up_trst_n),
    .up_tdo(up_tdo), .oe(oe), .lsp_tck(lsp_tck), .lsp_tms(lsp_tms),
    .lsp_tdi(lsp_tdi), .lsp_tdo(lsp_tdo), .lsp_trst_n(lsp_trst_n),
    .lsp_oe(lsp_oe), .lsp_hiz_flag(lsp_hiz_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    @(negedge tck);
  endtask

  task automatic load(input logic [1:0] op, input logic [N-1:0] m, input logic [2:0] s);
    cfg_op = op; cfg_mask = m; cfg_sel = s; cfg_load = 1;
    tick();
    cfg_load = 0;
  endtask

  task automatic t_reset();
    @(negedge tck);
    chk("R1 trst in reset", lsp_trst_n, 7'h00);
    rst_n = 1;
    up_tms = 1;
    tick();
    chk("R1 tms parked", lsp_tms, 7'h00);
    chk("R1 trst released", lsp_trst_n, 7'h7f);
    up_tdi = 1; tick();
    chk("R7 bypass 1", up_tdo, 1);
    up_tdi = 0;
    chk("R7 bypass holds until edge", up_tdo, 1);
    tick();
    chk("R7 bypass 0", up_tdo, 0);
  endtask

  task automatic t_chain();
    up_stable = 1; up_tms = 1;
    load(2'd1, 7'b0100101, 0);
    chk("R2 no effect at load edge", lsp_tms, 7'h00);
    tick();
    chk("R4 active tms", lsp_tms, 7'b0100101);
    up_tdi = 1; lsp_tdo = 7'b0000000;
    #1;
    chk("R3 first gets up_tdi", lsp_tdi[0], 1);
    chk("R3 port2 gets 0", lsp_tdi[2], 0);
    lsp_tdo = 7'b0000001; #1;
    chk("R3 port2 from port0", lsp_tdi[2], 1);
    chk("R3 port5 from port2", lsp_tdi[5], 0);
    lsp_tdo = 7'b0000100; #1;
    chk("R3 port5 from port2 hi", lsp_tdi[5], 1);
    chk("R3 up_tdo from port5 lo", up_tdo, 0);
    lsp_tdo = 7'b0100000; #1;
    chk("R3 up_tdo from port5", up_tdo, 1);
    up_trst_n = 0; #1;
    chk("R9 trst follows active", lsp_trst_n, 7'b1011010);
    up_trst_n = 1; lsp_tdo = 0; up_tdi = 0;
  endtask

  task automatic t_park_state();
    up_stable = 1; up_tms = 1;
    load(2'd1, 7'b0000001, 0); tick();
    chk("R4 port0 only", lsp_tms, 7'b0000001);
    up_stable = 0;
    load(2'd0, 0, 0); tick(); tick();
    chk("R6 no park while unstable", lsp_tms, 7'b0000001);
    up_stable = 2; tick();
    chk("R6 parked in pause-dr", lsp_tms, 7'h00);
    up_stable = 1;
    load(2'd1, 7'b0000001, 0); tick(); tick();
    chk("R5 stays parked on mismatch", lsp_tms, 7'h00);
    up_stable = 2; tick();
    chk("R5 rejoins on match", lsp_tms, 7'b0000001);
    load(2'd3, 0, 0); tick();
    chk("R2 op3 parks", lsp_tms, 7'h00);
  endtask

  task automatic t_xpar();
    up_stable = 1; up_tms = 1;
    load(2'd2, 7'h7f, 3'd3); tick();
    chk("R8 sel3 only", lsp_tms, 7'b0001000);
    lsp_tdo = 7'b0001000; #1;
    chk("R8 tdo from port3", up_tdo, 1);
    lsp_tdo = 0;
    load(2'd2, 7'h7f, 3'd7); tick();
    chk("R8 sel7 none", lsp_tms, 7'h00);
    up_tdi = 1; tick();
    chk("R7 bypass after xpar", up_tdo, 1);
  endtask

  task automatic t_oe();
    oe = 1; #1;
    chk("R10 oe on", {lsp_oe, lsp_hiz_flag}, {7'h7f, 4'h0});
    oe = 0; #1;
    chk("R10 oe off", {lsp_oe, lsp_hiz_flag}, {7'h00, 4'hf});
    oe = 1;
  endtask

  initial begin
    repeat (2) @(negedge tck);
    t_reset();
    t_chain();
    t_park_state();
    t_xpar();
    t_oe();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge tck);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule